// File: doc/BRIEF.md
# MDIO Management Master

This block is a station-management master for PHY register access. It shifts management frames onto a clock/data pair: a divided management clock (MDC) and a bidirectional data line. The data line is brought out as an output value, an output enable and an input sample. One command interface covers both the classic 5-bit register frames (clause 22) and the extended frames (clause 45). A mode bit in the configuration picks between them. In extended mode a full access takes two commands: an address cycle that loads the 16-bit register address, then a data cycle to the same PHY and device.

Software sets the configuration (mode, preamble enable, clock divider) and loads the write-data word. Writing the command then starts a frame. Two pending flags and a valid flag report progress:

- Write and address frames raise the write-pending flag.
- Read frames raise the read-pending flag.
- When a read ends, the 16 captured bits appear together with a valid flag. The valid flag is left clear when the PHY did not take over the line during turnaround.

Any word to be sent must reach the write-data register at least one cycle before the command that uses it.

Top module: `mdio_master`

## Requirements
- R1: After reset, both pending flags and the valid flag are 0, MDC is low and the data line is released (`mdio_oe` = 0).
- R2: While a frame runs, MDC has a period of 2*(div+1) system clocks, where div is the configured divider value. MDC stays low while no frame is in flight.
- R3: Each frame is sent MSB first in this order:
  - 32 ones, only when preamble is enabled;
  - 2 start bits;
  - 2 opcode bits;
  - 5 PHY-address bits;
  - 5 register/device bits;
  - 2 turnaround bits;
  - 16 data bits.
  A frame therefore has 64 MDC cycles with preamble and 32 without.
- R4: In classic mode (mode bit 0) the start bits are 01. Command code 0 is a write: opcode 01, turnaround 10, data taken from the write-data register. Command code 1 is a read: opcode 10.
- R5: In extended mode (mode bit 1) the start bits are 00 and the opcode bits equal the command code:
  - 0 is an address cycle, which sends the write-data word as the register address;
  - 1 is a write;
  - 2 is a read with post-increment;
  - 3 is a read.
- R6: The write-pending flag is 1 from the cycle after a write or address command is accepted until the MDC falling transition that ends the last bit.
- R7: A read clears the valid flag on acceptance and sets the read-pending flag. On the final MDC falling transition it clears read-pending, sets valid, and presents the 16 bits sampled on the MDC rising edges, MSB first.
- R8: During a read the master releases the line for both turnaround bits and all data bits. If the line is not low at the second turnaround bit, the read ends with valid = 0.
- R9: A command written while either pending flag is set is ignored: no frame starts and neither flag changes because of it.
- R10: The data line is released whenever no frame is in flight.
- R11: While the master drives the line, the driven value changes only together with an MDC falling transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ext_mode | input | 1 | 0 = clause 22 frames, 1 = clause 45 frames |
| cfg_pre_en | input | 1 | Send 32-bit preamble of ones |
| cfg_div | input | DIV_W | MDC half-period minus one, in system clocks |
| wdat_we | input | 1 | Write-data register write strobe |
| wdat_data | input | 16 | Write data or clause 45 register address |
| cmd_we | input | 1 | Command write strobe; starts a frame when idle |
| cmd_op | input | 2 | Command code |
| cmd_phy | input | 5 | PHY address |
| cmd_regad | input | 5 | Register address (clause 22) or device number (clause 45) |
| wr_pending | output | 1 | Write or address frame in flight |
| rd_pending | output | 1 | Read frame in flight |
| rd_valid | output | 1 | Last read completed correctly |
| rd_data | output | 16 | Data captured by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Driven value of the data line |
| mdio_oe | output | 1 | Drive enable of the data line |
| mdio_i | input | 1 | Sampled level of the data line |

## Verification
The hardest conditions to reach from the ports are two read cases. In the first, the PHY fails to pull the second turnaround bit low. In the second, a new command arrives in the middle of a frame. The bench contains a PHY model that watches MDC transitions, decodes its position in the frame, and drives turnaround and data bits after falling edges. It has a switch that leaves the second turnaround bit high to provoke the failed read. To hit the ignore window, a read command is issued a fixed number of cycles into a running write frame. The bench then confirms that the captured frame stays exactly the write frame and that no second frame follows.

// File: rtl/mdio_pkg.sv
// mdio_pkg: shared frame geometry and field codes for the management master.
// Assumes fixed 5-bit address fields and 16-bit data, as the frame format sets.
package mdio_pkg;
    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
    localparam int MAX_LEN   = PRE_LEN + FRAME_LEN;
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    localparam logic [1:0] START_C22 = 2'b01;
    localparam logic [1:0] START_C45 = 2'b00;
    localparam logic [1:0] TA_WRITE  = 2'b10;

    // Frame description handed from the framer to the shifter
    typedef struct packed {
        logic [MAX_LEN-1:0] bits;
        logic [CNT_W-1:0]   len;
        logic               is_read;
    } frame_t;
endpackage

// File: rtl/mdio_clkgen.sv
// mdio_clkgen: divides the system clock into MDC while enabled.
// Emits one-cycle rise/fall event flags aligned with the MDC toggle.
// Assumes en is held for the whole frame; MDC returns low when en drops.
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap     = en && (cnt == div);
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap && mdc;

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_framer.sv
// mdio_framer: combinational assembly of the bit stream for one command.
// Assumes the caller only uses its output in the cycle a command is accepted.
module mdio_framer
    import mdio_pkg::*;
(
    input  logic              ext_mode,
    input  logic              pre_en,
    input  logic [1:0]        op,
    input  logic [PHY_W-1:0]  phy,
    input  logic [REG_W-1:0]  regad,
    input  logic [DATA_W-1:0] wdata,
    output frame_t            frame
);
    logic [1:0]           start_bits;
    logic [1:0]           wire_op;
    logic                 rd;
    logic [FRAME_LEN-1:0] body;

    // Decode start bits, wire opcode and direction from the mode
    always_comb begin
        if (ext_mode) begin
            start_bits = START_C45;
            wire_op    = op;
            rd         = op[1];
        end else begin
            start_bits = START_C22;
            wire_op    = op[0] ? 2'b10 : 2'b01;
            rd         = op[0];
        end
    end

    assign body = {start_bits, wire_op, phy, regad, TA_WRITE,
                   rd ? {DATA_W{1'b1}} : wdata};

    // Place the body behind the optional preamble, MSB-aligned
    always_comb begin
        frame.is_read = rd;
        if (pre_en) begin
            frame.bits = {{PRE_LEN{1'b1}}, body};
            frame.len  = CNT_W'(MAX_LEN);
        end else begin
            frame.bits = {body, {PRE_LEN{1'b0}}};
            frame.len  = CNT_W'(FRAME_LEN);
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
// mdio_shifter: shifts a frame out on MDC falling events, samples read
// turnaround and data on rising events, and flags completion.
// Assumes rise_evt/fall_evt come from a divider enabled by busy.
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  frame_t            frame,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              rd_ok,
    output logic [DATA_W-1:0] rd_word
);
    localparam logic [CNT_W-1:0] TA2_LEFT  = CNT_W'(DATA_W + 1);
    localparam logic [CNT_W-1:0] REL_LEFT  = CNT_W'(DATA_W + 2);
    localparam logic [CNT_W-1:0] DATA_LEFT = CNT_W'(DATA_W);

    logic [MAX_LEN-1:0] shreg;
    logic [CNT_W-1:0]   left;
    logic               rd;
    logic               ta_bad;

    assign mdio_o  = shreg[MAX_LEN-1];
    assign mdio_oe = busy && !(rd && left <= REL_LEFT);
    assign done    = busy && fall_evt && left == CNT_W'(1);
    assign rd_ok   = !ta_bad;

    // Frame sequencing: load, shift on fall, capture on rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            shreg   <= '0;
            left    <= '0;
            rd      <= 1'b0;
            ta_bad  <= 1'b0;
            rd_word <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            shreg  <= frame.bits;
            left   <= frame.len;
            rd     <= frame.is_read;
            ta_bad <= 1'b0;
        end else if (busy) begin
            if (rise_evt && rd) begin
                if (left == TA2_LEFT && mdio_i)
                    ta_bad <= 1'b1;
                if (left <= DATA_LEFT)
                    rd_word <= {rd_word[DATA_W-2:0], mdio_i};
            end
            if (fall_evt) begin
                if (left == CNT_W'(1)) begin
                    busy <= 1'b0;
                end else begin
                    shreg <= shreg << 1;
                    left  <= left - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// mdio_master: management master top. Holds configuration, write data and
// status flags, accepts commands when idle and runs one frame per command.
// Assumes write data is loaded at least one cycle before its command.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int              DIV_W   = 8,
    parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_ext_mode,
    input  logic              cfg_pre_en,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              wdat_we,
    input  logic [DATA_W-1:0] wdat_data,
    input  logic              cmd_we,
    input  logic [1:0]        cmd_op,
    input  logic [PHY_W-1:0]  cmd_phy,
    input  logic [REG_W-1:0]  cmd_regad,
    output logic              wr_pending,
    output logic              rd_pending,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              ext_q, pre_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] wdata_q;
    frame_t            frame;
    logic              accept, busy, rise_evt, fall_evt, done, rd_ok;
    logic [DATA_W-1:0] rd_word;

    assign accept = cmd_we && !wr_pending && !rd_pending;

    // Configuration and write-data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q   <= 1'b0;
            pre_q   <= 1'b1;
            div_q   <= DIV_RST;
            wdata_q <= '0;
        end else begin
            if (cfg_we) begin
                ext_q <= cfg_ext_mode;
                pre_q <= cfg_pre_en;
                div_q <= cfg_div;
            end
            if (wdat_we)
                wdata_q <= wdat_data;
        end
    end

    // Pending, valid and read-data status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pending <= 1'b0;
            rd_pending <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else if (accept) begin
            if (frame.is_read) begin
                rd_pending <= 1'b1;
                rd_valid   <= 1'b0;
            end else begin
                wr_pending <= 1'b1;
            end
        end else if (done) begin
            wr_pending <= 1'b0;
            rd_pending <= 1'b0;
            if (rd_pending) begin
                rd_valid <= rd_ok;
                rd_data  <= rd_word;
            end
        end
    end

    mdio_framer u_framer (
        .ext_mode (ext_q),
        .pre_en   (pre_q),
        .op       (cmd_op),
        .phy      (cmd_phy),
        .regad    (cmd_regad),
        .wdata    (wdata_q),
        .frame    (frame)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (busy),
        .div      (div_q),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_shifter u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .frame    (frame),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_ok    (rd_ok),
        .rd_word  (rd_word)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// mdio_master_chk: protocol checks on the master's ports, bound to the top.
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic wr_pending,
    input logic rd_pending,
    input logic rd_valid
);
    // R2
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pending && !rd_pending) |-> !mdc);

    // R10
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pending && !rd_pending) |-> !mdio_oe);

    // R6
    wr_end_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_pending) |-> $fell(mdc));

    // R7
    rd_end_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_pending) |-> $fell(mdc));

    // R7
    rd_start_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_pending) |-> !rd_valid);

    // R8
    valid_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $fell(rd_pending));

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_pending) || $rose(wr_pending)) |-> $past(!wr_pending && !rd_pending));

    // R11
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .wr_pending (wr_pending),
    .rd_pending (rd_pending),
    .rd_valid   (rd_valid)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
// mdio_master_tb: directed scenarios with a behavioural PHY on the data line.
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_ext_mode = 1'b0, cfg_pre_en = 1'b1;
    logic [7:0]  cfg_div = 8'd1;
    logic        wdat_we = 1'b0;
    logic [15:0] wdat_data = '0;
    logic        cmd_we = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [4:0]  cmd_phy = '0, cmd_regad = '0;
    logic        wr_pending, rd_pending, rd_valid, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_line;

    // PHY model state
    logic        phy_oe = 1'b0, phy_o = 1'b1;
    logic        resp_rd = 1'b0, resp_ta = 1'b0;
    logic [15:0] resp_reply = '0;
    int          cur_pre = 32;
    logic [63:0] cap = '0;
    int          ncap = 0;
    logic        oe_bad = 1'b0;
    logic        mdc_q = 1'b0, oe_q = 1'b0, o_q = 1'b0;
    int          glitches = 0;
    int          cyc = 0, rise_cyc = 0, period = 0;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = !clk;

    assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ext_mode(cfg_ext_mode), .cfg_pre_en(cfg_pre_en), .cfg_div(cfg_div),
        .wdat_we(wdat_we), .wdat_data(wdat_data),
        .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_phy(cmd_phy), .cmd_regad(cmd_regad),
        .wr_pending(wr_pending), .rd_pending(rd_pending), .rd_valid(rd_valid), .rd_data(rd_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    // Line monitor and PHY responder, sampled between clock edges
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mdio_oe && !oe_q) begin
            ncap   = 0;
            cap    = '0;
            oe_bad = 1'b0;
        end
        if (mdio_oe && oe_q && mdio_o != o_q && !(!mdc && mdc_q))
            glitches++;
        if (mdc && !mdc_q) begin
            if (resp_rd && ncap >= cur_pre + 14 && mdio_oe)
                oe_bad = 1'b1;
            cap  = {cap[62:0], mdio_line};
            ncap = ncap + 1;
            period   = cyc - rise_cyc;
            rise_cyc = cyc;
        end
        if (!mdc && mdc_q) begin
            if (resp_rd && ncap == cur_pre + 15) begin
                phy_oe = 1'b1;
                phy_o  = resp_ta;
            end else if (resp_rd && ncap >= cur_pre + 16 && ncap < cur_pre + 32) begin
                phy_oe = 1'b1;
                phy_o  = resp_reply[cur_pre + 31 - ncap];
            end else begin
                phy_oe = 1'b0;
            end
        end
        mdc_q = mdc;
        oe_q  = mdio_oe;
        o_q   = mdio_o;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input bit ext, input bit pre, input logic [7:0] div);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ext_mode = ext; cfg_pre_en = pre; cfg_div = div;
        cur_pre = pre ? 32 : 0;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_wdat(input logic [15:0] d);
        @(negedge clk);
        wdat_we = 1'b1; wdat_data = d;
        @(negedge clk);
        wdat_we = 1'b0;
    endtask

    // Issue a command; returns after the accept edge
    task automatic issue(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rad);
        @(negedge clk);
        cmd_we = 1'b1; cmd_op = op; cmd_phy = phy; cmd_regad = rad;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            if (!wr_pending && !rd_pending) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [63:0] exp_line(input logic [31:0] body, input bit pre);
        return pre ? {32'hFFFF_FFFF, body} : {32'h0, body};
    endfunction

    task automatic t_reset();
        check(!wr_pending && !rd_pending && !rd_valid, "R1 flags", {wr_pending, rd_pending, rd_valid}, 0);
        check(!mdc && !mdio_oe, "R1 mdc/oe", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_write22();
        resp_rd = 1'b0;
        set_cfg(1'b0, 1'b1, 8'd1);
        set_wdat(16'hBEEF);
        issue(2'd0, 5'h03, 5'h04);
        check(wr_pending && !rd_pending, "R6 pending set", {wr_pending, rd_pending}, 2'b10);
        wait_idle();
        check(ncap == 64, "R3 length", ncap, 64);
        check(cap == exp_line({2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'hBEEF}, 1'b1), "R4 write frame",
              cap, exp_line({2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'hBEEF}, 1'b1));
        check(period == 4, "R2 period div1", period, 4);
        @(negedge clk);
        check(!wr_pending && !mdio_oe && !mdc, "R10 released after write", {wr_pending, mdio_oe, mdc}, 0);
    endtask

    task automatic t_read(input bit ext, input bit pre, input logic [1:0] op, input logic [1:0] wop,
                          input logic [15:0] reply, input bit ta, input string req);
        logic [63:0] e;
        resp_rd = 1'b1; resp_reply = reply; resp_ta = ta;
        set_cfg(ext, pre, 8'd1);
        issue(op, 5'h1F, 5'h01);
        check(rd_pending && !rd_valid, {req, " rd pending"}, {rd_pending, rd_valid}, 2'b10);
        wait_idle();
        e = exp_line({ext ? 2'b00 : 2'b01, wop, 5'h1F, 5'h01, 1'b1, ta, reply}, pre);
        check(ncap == (pre ? 64 : 32), {req, " length"}, ncap, pre ? 64 : 32);
        check(cap == e, {req, " read frame"}, cap, e);
        check(!oe_bad, "R8 released in turnaround/data", oe_bad, 0);
        check(rd_valid == !ta, {req, " valid"}, rd_valid, !ta);
        if (!ta) check(rd_data == reply, "R7 data", rd_data, reply);
        resp_rd = 1'b0;
    endtask

    task automatic t_ext_addr_write();
        resp_rd = 1'b0;
        set_cfg(1'b1, 1'b1, 8'd3);
        set_wdat(16'h1234);
        issue(2'd0, 5'h02, 5'h03);
        check(wr_pending, "R6 address pending", wr_pending, 1);
        wait_idle();
        check(cap == exp_line({2'b00, 2'b00, 5'h02, 5'h03, 2'b10, 16'h1234}, 1'b1), "R5 address frame",
              cap, exp_line({2'b00, 2'b00, 5'h02, 5'h03, 2'b10, 16'h1234}, 1'b1));
        check(period == 8, "R2 period div3", period, 8);
        set_wdat(16'hCAFE);
        issue(2'd1, 5'h02, 5'h03);
        wait_idle();
        check(cap == exp_line({2'b00, 2'b01, 5'h02, 5'h03, 2'b10, 16'hCAFE}, 1'b1), "R5 write frame",
              cap, exp_line({2'b00, 2'b01, 5'h02, 5'h03, 2'b10, 16'hCAFE}, 1'b1));
    endtask

    task automatic t_ignore_busy();
        resp_rd = 1'b0;
        set_cfg(1'b0, 1'b1, 8'd1);
        set_wdat(16'h5A5A);
        issue(2'd0, 5'h07, 5'h09);
        repeat (20) @(negedge clk);
        issue(2'd1, 5'h11, 5'h12);
        check(!rd_pending && wr_pending, "R9 ignored flags", {wr_pending, rd_pending}, 2'b10);
        wait_idle();
        check(cap == exp_line({2'b01, 2'b01, 5'h07, 5'h09, 2'b10, 16'h5A5A}, 1'b1), "R9 frame unchanged",
              cap, exp_line({2'b01, 2'b01, 5'h07, 5'h09, 2'b10, 16'h5A5A}, 1'b1));
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (mdc || mdio_oe || rd_pending) begin
                check(1'b0, "R9 no second frame", {mdc, mdio_oe, rd_pending}, 0);
                break;
            end
        end
        check(!mdc && !mdio_oe, "R2 idle mdc low / R10", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_div0();
        resp_rd = 1'b0;
        set_cfg(1'b0, 1'b0, 8'd0);
        issue(2'd0, 5'h01, 5'h02);
        wait_idle();
        check(period == 2, "R2 period div0", period, 2);
        check(ncap == 32, "R3 no preamble length", ncap, 32);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write22();
        t_read(1'b0, 1'b1, 2'd1, 2'b10, 16'hA5C3, 1'b0, "R4 c22 read");
        t_read(1'b0, 1'b0, 2'd1, 2'b10, 16'h3C5A, 1'b0, "R3 c22 read no preamble");
        t_ext_addr_write();
        t_read(1'b1, 1'b1, 2'd3, 2'b11, 16'h0F0F, 1'b0, "R5 c45 read");
        t_read(1'b1, 1'b1, 2'd2, 2'b10, 16'h8001, 1'b0, "R5 c45 read-inc");
        t_read(1'b0, 1'b1, 2'd1, 2'b10, 16'hFFFF, 1'b1, "R8 turnaround fail");
        t_ignore_busy();
        t_div0();
        check(glitches == 0, "R11 drive changes on fall only", glitches, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule